// File: doc/BRIEF.md
# Eight-Input Byte-Programmed Priority Interrupt Controller

This block gathers eight interrupt request lines and signals the processor when one of them needs service. Software sees it as two byte-wide locations chosen by a single select bit. Select 0 is the command location and select 1 is the data location. After reset or after a start word, software writes a short chain of configuration bytes: a start word, a vector base, an optional cascade byte and an optional mode byte. From then on, data writes load the interrupt mask.

Requests are caught on rising edges and ranked with level 0 as the most urgent. A request can raise the interrupt output only when it is unmasked and more urgent than everything already in service. Software services interrupts by polling: it writes a poll command, and the next command read returns the winning level and acknowledges it. A non-specific end-of-interrupt retires the most urgent in-service level. A read-select command chooses whether command reads show the pending set or the in-service set. Two instances can be used as master and slave by wiring a slave's interrupt output into one of the master's inputs.

Top module: `prio_int_ctrl`

## Requirements
- R1: After reset, the pending and in-service sets are empty, the mask reads 0xFF, command reads return the pending set, and `int_out` is low.
- R2: A command write with bit 4 set starts configuration. The next data write loads the vector base from its bits 7:3. If bit 1 of the start word was clear, one more data byte (the cascade byte) is consumed. If bit 0 of the start word was set, one more data byte (the mode byte) is consumed after that. `vec_out` carries the base in bits 7:3 and the winning level in bits 2:0.
- R3: Once configuration is done, a data write loads the mask and a data read returns it. A mask bit of 1 keeps that input from raising `int_out` and from winning a poll.
- R4: A pending bit is set only when its input goes from low to high. It is cleared while its input is low and when its level is acknowledged. An input that stays high after its acknowledge is not latched again.
- R5: Level 0 has the highest priority. `int_out` is high exactly when an unmasked pending level exists that is strictly more urgent than every in-service level.
- R6: A command write of 0x0C arms a poll. The next command read returns 0x80 plus the winning level, sets that level's in-service bit and clears its pending bit.
- R7: A poll read that finds no eligible request returns 0x07 and leaves the in-service set unchanged.
- R8: Command write 0x0B selects the in-service set for command reads, and 0x0A selects the pending set. The selection stays in force until it is changed.
- R9: Command write 0x20 clears the lowest-numbered set bit of the in-service set.
- R10: A start word clears the mask to 0x00 and reselects the pending set for command reads. Command words other than a start word are ignored until configuration ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| port_sel | input | 1 | 0 selects the command location, 1 selects the data location |
| wr_en | input | 1 | Write strobe; takes precedence over rd_en |
| rd_en | input | 1 | Read strobe; a command read consumes an armed poll |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected location, valid in the cycle of the strobe |
| irq_in | input | 8 | Interrupt request lines |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector base concatenated with the current winning level |

## Verification
A poll acknowledge and a fresh rising edge on another input can land on the same clock edge. The acknowledge clears one pending bit while the edge detector sets a different one. The bench raises input 1 in the very cycle the poll read of level 2 is strobed. It checks three things: the read reports only level 2, the pending set afterwards holds just bit 1, and `int_out` rises again because level 1 outranks the level now in service.

// File: rtl/pic_pkg.sv
// Package: shared widths and the configuration-sequence state type for the
// priority interrupt controller. Assumes the level field is 3 bits wide.
package pic_pkg;
    localparam int PIC_LVL_W = 3;
    localparam int PIC_N     = 1 << PIC_LVL_W;
    localparam int PIC_BASE_W = 8 - PIC_LVL_W;

    typedef enum logic [1:0] {
        CFG_READY = 2'd0,
        CFG_BASE  = 2'd1,
        CFG_CASC  = 2'd2,
        CFG_MODE  = 2'd3
    } cfg_state_t;

    localparam logic [4:0] EOI_NONSPEC = 5'b00100;
endpackage

// File: rtl/pic_cfg.sv
// Module: configuration and command decoder. It tracks the start / base /
// cascade / mode byte chain, holds the mask, the vector base, the readback
// selection and the poll-armed flag, and it decodes end-of-interrupt.
// Assumes at most one of cmd_wr, dat_wr and cmd_rd is high in a cycle.
module pic_cfg
    import pic_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_wr,
    input  logic                  dat_wr,
    input  logic                  cmd_rd,
    input  logic [7:0]            wdata,
    output logic [PIC_N-1:0]      mask,
    output logic [PIC_BASE_W-1:0] base,
    output logic                  sel_isr,
    output logic                  poll_armed,
    output logic                  eoi
);
    cfg_state_t state;
    logic       need_mode;
    logic       cascaded;
    logic       start;

    // Purpose: recognise a start word on the command location.
    always_comb start = cmd_wr && wdata[4];

    // Purpose: recognise a non-specific end-of-interrupt while operating.
    always_comb eoi = cmd_wr && (state == CFG_READY) && (wdata[7:3] == EOI_NONSPEC);

    // Purpose: advance the configuration chain and update the operating registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= CFG_READY;
            need_mode  <= 1'b0;
            cascaded   <= 1'b0;
            mask       <= '1;
            base       <= '0;
            sel_isr    <= 1'b0;
            poll_armed <= 1'b0;
        end else if (start) begin
            state      <= CFG_BASE;
            need_mode  <= wdata[0];
            cascaded   <= ~wdata[1];
            mask       <= '0;
            sel_isr    <= 1'b0;
            poll_armed <= 1'b0;
        end else begin
            case (state)
                CFG_BASE: if (dat_wr) begin
                    base  <= wdata[7:PIC_LVL_W];
                    state <= cascaded ? CFG_CASC : (need_mode ? CFG_MODE : CFG_READY);
                end
                CFG_CASC: if (dat_wr) state <= need_mode ? CFG_MODE : CFG_READY;
                CFG_MODE: if (dat_wr) state <= CFG_READY;
                default: begin
                    if (dat_wr) mask <= wdata;
                    if (cmd_wr && wdata[3]) begin
                        if (wdata[1]) sel_isr <= wdata[0];
                        if (wdata[2]) poll_armed <= 1'b1;
                    end else if (cmd_rd) begin
                        poll_armed <= 1'b0;
                    end
                end
            endcase
        end
    end

    AST_START_CLEARS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (mask == '0) && !sel_isr && !poll_armed); // R10
endmodule

// File: rtl/pic_irr.sv
// Module: request latch. It catches a rising edge on each input into the
// pending set, drops a bit while its input is low, and clears the bit that
// is being acknowledged. Assumes the inputs are already synchronous to clk.
module pic_irr
    import pic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIC_N-1:0] irq_in,
    input  logic [PIC_N-1:0] ack_vec,
    output logic [PIC_N-1:0] irr
);
    logic [PIC_N-1:0] prev;

    // Purpose: remember the previous input levels and update the pending set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= '0;
            irr  <= '0;
        end else begin
            prev <= irq_in;
            irr  <= (irr | (irq_in & ~prev)) & irq_in & ~ack_vec;
        end
    end

    AST_IRR_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((irr & ~$past(irr) & ~$past(irq_in)) == '0)); // R4
endmodule

// File: rtl/pic_prio.sv
// Module: fixed-priority resolver. It finds the lowest-numbered unmasked
// pending level and blocks it when an equal or more urgent level is already
// in service. Purely combinational.
module pic_prio
    import pic_pkg::*;
(
    input  logic [PIC_N-1:0]     irr,
    input  logic [PIC_N-1:0]     mask,
    input  logic [PIC_N-1:0]     isr,
    output logic                 req_valid,
    output logic [PIC_LVL_W-1:0] req_lvl
);
    logic [PIC_N-1:0] cand;
    logic             stop;

    // Purpose: scan from level 0 upward, stopping at the first in-service or eligible level.
    always_comb begin
        cand      = irr & ~mask;
        req_valid = 1'b0;
        req_lvl   = '1;
        stop      = 1'b0;
        for (int i = 0; i < PIC_N; i++) begin
            if (!stop) begin
                if (isr[i]) begin
                    stop = 1'b1;
                end else if (cand[i]) begin
                    req_valid = 1'b1;
                    req_lvl   = PIC_LVL_W'(i);
                    stop      = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/prio_int_ctrl.sv
// Module: top of the eight-input priority interrupt controller. It joins the
// configuration decoder, the request latch and the resolver, holds the
// in-service set, and drives the read mux. Assumes one access per cycle;
// a write wins over a simultaneous read.
module prio_int_ctrl
    import pic_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       port_sel,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic [7:0] irq_in,
    output logic       int_out,
    output logic [7:0] vec_out
);
    logic                  cmd_wr, dat_wr, cmd_rd;
    logic [PIC_N-1:0]      mask, irr, isr, ack_vec, eoi_clr;
    logic [PIC_BASE_W-1:0] base;
    logic                  sel_isr, poll_armed, eoi;
    logic                  req_valid, ack;
    logic [PIC_LVL_W-1:0]  req_lvl;
    logic [7:0]            poll_byte;
    logic                  found;

    // Purpose: split the strobes into command/data accesses.
    always_comb begin
        cmd_wr = wr_en && !port_sel;
        dat_wr = wr_en && port_sel;
        cmd_rd = rd_en && !wr_en && !port_sel;
    end

    pic_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .dat_wr(dat_wr),
        .cmd_rd(cmd_rd), .wdata(wdata), .mask(mask), .base(base),
        .sel_isr(sel_isr), .poll_armed(poll_armed), .eoi(eoi)
    );

    pic_irr u_irr (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack_vec(ack_vec), .irr(irr)
    );

    pic_prio u_prio (
        .irr(irr), .mask(mask), .isr(isr), .req_valid(req_valid), .req_lvl(req_lvl)
    );

    // Purpose: form the acknowledge vector for a poll read that finds a winner.
    always_comb begin
        ack     = cmd_rd && poll_armed && req_valid;
        ack_vec = ack ? (PIC_N'(1) << req_lvl) : '0;
    end

    // Purpose: pick the lowest-numbered in-service bit for end-of-interrupt.
    always_comb begin
        eoi_clr = '0;
        found   = 1'b0;
        for (int i = 0; i < PIC_N; i++) begin
            if (!found && isr[i]) begin
                eoi_clr[i] = 1'b1;
                found      = 1'b1;
            end
        end
    end

    // Purpose: set in-service bits on acknowledge and retire them on end-of-interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) isr <= '0;
        else        isr <= (isr | ack_vec) & ~(eoi ? eoi_clr : '0);
    end

    // Purpose: build the poll result and the read mux.
    always_comb begin
        poll_byte = req_valid ? {1'b1, {(7-PIC_LVL_W){1'b0}}, req_lvl} : 8'h07;
        if (port_sel)        rdata = mask;
        else if (poll_armed) rdata = poll_byte;
        else if (sel_isr)    rdata = isr;
        else                 rdata = irr;
    end

    assign int_out = req_valid;
    assign vec_out = {base, req_lvl};

    AST_INT_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((irr & ~mask) != '0)); // R5
    AST_ISR_ONE_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rd |=> ($countones(isr) <= $countones($past(isr)) + 1)); // R6
    AST_EOI_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && isr != '0) |=> ($countones(isr) + 1 == $countones($past(isr)))); // R9
    AST_SPURIOUS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rd && poll_armed && !int_out) |=> (isr == $past(isr))); // R7
endmodule

// File: tb/tb_prio_int_ctrl.sv
module tb_prio_int_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0, irq_in = '0;
    logic [7:0] rdata, vec_out;
    logic       int_out;
    int         n_chk = 0, n_fail = 0;
    bit         done = 0;

    always #5 clk = ~clk;

    prio_int_ctrl dut (
        .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .int_out(int_out), .vec_out(vec_out)
    );

    // entry: {req[3:0], op[2:0], sel, data}; op 0 write, 1 read, 2 set inputs, 3 int_out, 4 vec_out
    localparam int NV = 32;
    localparam logic [15:0] TBL [NV] = '{
        {4'd1, 3'd1, 1'b0, 8'h00},  // R1 pending readback empty
        {4'd1, 3'd1, 1'b1, 8'hFF},  // R1 mask all ones
        {4'd1, 3'd3, 1'b0, 8'h00},  // R1 int low
        {4'd2, 3'd0, 1'b0, 8'h11},  // R2 start, cascade, mode byte follows
        {4'd2, 3'd0, 1'b1, 8'h08},  // R2 base
        {4'd2, 3'd0, 1'b1, 8'h02},  // R2 cascade byte
        {4'd2, 3'd0, 1'b1, 8'h01},  // R2 mode byte
        {4'd10,3'd1, 1'b1, 8'h00},  // R10 start cleared mask
        {4'd3, 3'd0, 1'b1, 8'hF0},  // R3 mask upper nibble
        {4'd3, 3'd1, 1'b1, 8'hF0},  // R3 readback
        {4'd4, 3'd2, 1'b0, 8'h28},  // R4 raise inputs 3 and 5
        {4'd5, 3'd3, 1'b0, 8'h01},  // R5 level 3 unmasked
        {4'd4, 3'd1, 1'b0, 8'h28},  // R4 both latched
        {4'd2, 3'd4, 1'b0, 8'h0B},  // R2 vector = base 0x08 + 3
        {4'd6, 3'd0, 1'b0, 8'h0C},  // R6 arm poll
        {4'd6, 3'd1, 1'b0, 8'h83},  // R6 poll result
        {4'd8, 3'd0, 1'b0, 8'h0B},  // R8 select in-service
        {4'd6, 3'd1, 1'b0, 8'h08},  // R6 in-service bit 3
        {4'd5, 3'd3, 1'b0, 8'h00},  // R5 blocked by in-service 3
        {4'd5, 3'd2, 1'b0, 8'h2A},  // R5 raise input 1
        {4'd5, 3'd3, 1'b0, 8'h01},  // R5 level 1 outranks 3
        {4'd8, 3'd1, 1'b0, 8'h08},  // R8 selection persists
        {4'd9, 3'd0, 1'b0, 8'h20},  // R9 end-of-interrupt
        {4'd9, 3'd1, 1'b0, 8'h00},  // R9 in-service empty
        {4'd8, 3'd0, 1'b0, 8'h0A},  // R8 select pending
        {4'd4, 3'd1, 1'b0, 8'h22},  // R4 held-high input 3 not relatched
        {4'd4, 3'd2, 1'b0, 8'h00},  // R4 drop all inputs
        {4'd4, 3'd1, 1'b0, 8'h00},  // R4 cleared while low
        {4'd7, 3'd0, 1'b0, 8'h0C},  // R7 arm poll
        {4'd7, 3'd1, 1'b0, 8'h07},  // R7 nothing pending
        {4'd7, 3'd0, 1'b0, 8'h0B},  // R7 select in-service
        {4'd7, 3'd1, 1'b0, 8'h00}   // R7 in-service unchanged
    };

    task automatic chk(input int req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic s, input logic [7:0] d);
        @(negedge clk);
        port_sel = s; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1 wr_en = 1'b0;
    endtask

    task automatic rd(input int req, input logic s, input logic [7:0] exp);
        @(negedge clk);
        port_sel = s; rd_en = 1'b1;
        #2 chk(req, rdata, exp);
        @(posedge clk); #1 rd_en = 1'b0;
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk); irq_in = v;
    endtask

    task automatic chk_int(input int req, input logic e);
        @(negedge clk); #2 chk(req, {7'd0, int_out}, {7'd0, e});
    endtask

    task automatic do_reset();
        @(negedge clk); irq_in = '0; rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        for (int k = 0; k < NV; k++) begin
            case (TBL[k][11:9])
                3'd0: wr(TBL[k][8], TBL[k][7:0]);
                3'd1: rd(int'(TBL[k][15:12]), TBL[k][8], TBL[k][7:0]);
                3'd2: set_irq(TBL[k][7:0]);
                3'd3: chk_int(int'(TBL[k][15:12]), TBL[k][0]);
                default: begin
                    @(negedge clk); #2 chk(int'(TBL[k][15:12]), vec_out, TBL[k][7:0]);
                end
            endcase
        end

        // R10: command words ignored during configuration
        do_reset();
        set_irq(8'h04);
        wr(1'b0, 8'h11);
        wr(1'b0, 8'h0B);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h04);
        wr(1'b1, 8'h01);
        rd(10, 1'b0, 8'h04);

        // R6/R4: poll acknowledge coinciding with a new edge on input 1
        wr(1'b0, 8'h0C);
        @(negedge clk);
        port_sel = 1'b0; rd_en = 1'b1; irq_in = 8'h06;
        #2 chk(6, rdata, 8'h82);
        @(posedge clk); #1 rd_en = 1'b0;
        rd(4, 1'b0, 8'h02);
        chk_int(5, 1'b1);
        wr(1'b0, 8'h0B);
        rd(6, 1'b0, 8'h04);

        // R9: two levels in service, end-of-interrupt retires the most urgent
        wr(1'b0, 8'h0C);
        rd(6, 1'b0, 8'h81);
        rd(9, 1'b0, 8'h06);
        wr(1'b0, 8'h20);
        rd(9, 1'b0, 8'h04);

        // R1: reset from a busy state
        do_reset();
        rd(1, 1'b1, 8'hFF);
        rd(1, 1'b0, 8'h00);
        chk_int(1, 1'b0);

        // R2: no cascade byte, no mode byte
        wr(1'b0, 8'h12);
        wr(1'b1, 8'h40);
        wr(1'b1, 8'h5A);
        rd(2, 1'b1, 8'h5A);
        set_irq(8'h01);
        @(negedge clk); #2 chk(2, vec_out, 8'h40);
        chk_int(5, 1'b1);

        // R3: masked request neither interrupts nor wins a poll
        wr(1'b1, 8'hFF);
        chk_int(3, 1'b0);
        wr(1'b0, 8'h0C);
        rd(3, 1'b0, 8'h07);

        finish_run();
    end
endmodule